// File: doc/BRIEF.md
# Test Command Decoder

This block turns a 16-bit command word, written by a control system, into the test-mode controls of six RF daughter boards. The word has a 4-bit command code, two 4-bit attenuator codes and four spare bits. One command field covers two kinds of request. Some codes select a single board for a functional test. Other codes select a pair of boards for an X or Y position-offset test.

The word is captured on a one-cycle write strobe. Every output is held in a register and changes only on a write. The two attenuator codes are shared by all boards, and each code step is 2 dB of loss. Two command codes, all-zeros and all-ones, ask for a module reset. A reset write deselects everything and drives a reset pulse of fixed length.

Top module: `tst_cmd_decoder`

## Requirements
- R1: On every write, att_a_o loads word bits 7:4 and att_b_o loads word bits 11:8, whatever the command is. The value appears in the cycle after the write edge. An attenuator code n means 2·n dB of loss, and the same codes drive all boards.
- R2: Command codes 1 to 6 (word bits 3:0) set only bit n-1 of brd_sel_o. They also set rf_en_o to 1, pair_test_o to 0 and test_y_o to 0.
- R3: Codes 1000 and 1001 select boards 1 and 2 (brd_sel_o = 000011). Codes 1010 and 1011 select boards 3 and 4 (brd_sel_o = 001100). For these codes pair_test_o = 1, rf_en_o = 1, and test_y_o equals code bit 0 (0 = X test, 1 = Y test).
- R4: Codes 0000 and 1111 drive brd_sel_o, pair_test_o, test_y_o and rf_en_o to 0, and start a module reset pulse.
- R5: mod_rst_o is high for exactly RST_LEN cycles (default 16), starting in the cycle after the reset write. A new reset write during the pulse starts a full-length pulse again.
- R6: Codes 0111, 1100, 1101 and 1110 deselect every board, drive rf_en_o, pair_test_o and test_y_o to 0, and start no reset pulse.
- R7: When wr_i is low, no output changes except the countdown of mod_rst_o. Spare bits 15:12 have no effect.
- R8: While rst_ni is low, every output is 0.
- R9: rf_en_o is 1 exactly when at least one board is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle |
| word_i | input | 16 | Command word |
| brd_sel_o | output | 6 | Board select, bit n-1 = board n |
| pair_test_o | output | 1 | Paired position test active |
| test_y_o | output | 1 | 1 = Y test, 0 = X test |
| rf_en_o | output | 1 | Test RF enable |
| att_a_o | output | 4 | Attenuator A code |
| att_b_o | output | 4 | Attenuator B code |
| mod_rst_o | output | 1 | Module reset pulse |

## Verification
The bench writes all sixteen command codes with changing attenuator and spare bits. A decoder that mixes up the pair codes would select the wrong board pair or report X in place of Y. A decoder that misses one of the two reset codes would leave the boards selected with no pulse. A decoder that treats an undefined code as a board select would leave test RF enabled. The bench counts the pulse length both after a single reset write and after a second reset write during the pulse. A counter that is off by one, or that does not restart, gives the wrong length. Writes with the spare bits set, and idle cycles with a changed word on the bus, show whether the design samples anything outside the strobe.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  localparam int unsigned NUM_BRD = 6;
  localparam int unsigned CMD_W   = 4;
  localparam int unsigned ATT_W   = 4;
  localparam int unsigned SPARE_W = 4;
  localparam int unsigned WORD_W  = CMD_W + 2 * ATT_W + SPARE_W;
  localparam int unsigned ATT_A_LSB = CMD_W;
  localparam int unsigned ATT_B_LSB = CMD_W + ATT_W;

  typedef logic [CMD_W-1:0]   cmd_t;
  typedef logic [ATT_W-1:0]   att_t;
  typedef logic [NUM_BRD-1:0] sel_t;

  typedef struct packed {
    sel_t sel;
    logic pair;
    logic y;
    logic en;
    logic rst_req;
  } dec_t;
endpackage

// File: rtl/tcd_decode.sv
module tcd_decode
  import tcd_pkg::*;
(
  input  cmd_t cmd_i,
  output dec_t dec_o
);
  sel_t single_hit;
  sel_t pair_sel;
  logic is_pair;

  for (genvar g = 0; g < NUM_BRD; g++) begin : g_single
    assign single_hit[g] = (cmd_i == CMD_W'(g + 1));
  end

  // 10xx: bit1 picks the board pair, bit0 picks the axis
  assign is_pair  = (cmd_i[CMD_W-1 -: 2] == 2'b10);
  assign pair_sel = cmd_i[1] ? sel_t'(6'b001100) : sel_t'(6'b000011);

  always_comb begin
    dec_o         = '0;
    dec_o.rst_req = (cmd_i == '0) || (cmd_i == '1);
    if (|single_hit) begin
      dec_o.sel = single_hit;
      dec_o.en  = 1'b1;
    end else if (is_pair) begin
      dec_o.sel  = pair_sel;
      dec_o.pair = 1'b1;
      dec_o.y    = cmd_i[0];
      dec_o.en   = 1'b1;
    end
  end
endmodule

// File: rtl/tcd_pulse.sv
module tcd_pulse #(
  parameter int unsigned RST_LEN = 16,
  localparam int unsigned CNT_W  = $clog2(RST_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CNT_W'(RST_LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/tst_cmd_decoder.sv
module tst_cmd_decoder
  import tcd_pkg::*;
#(
  parameter int unsigned RST_LEN = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic [NUM_BRD-1:0]  brd_sel_o,
  output logic                pair_test_o,
  output logic                test_y_o,
  output logic                rf_en_o,
  output logic [ATT_W-1:0]    att_a_o,
  output logic [ATT_W-1:0]    att_b_o,
  output logic                mod_rst_o
);
  dec_t dec;
  dec_t dec_q;
  att_t att_a_q, att_b_q;

  tcd_decode i_decode (
    .cmd_i (word_i[CMD_W-1:0]),
    .dec_o (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q   <= '0;
      att_a_q <= '0;
      att_b_q <= '0;
    end else if (wr_i) begin
      dec_q   <= dec;
      att_a_q <= word_i[ATT_A_LSB +: ATT_W];
      att_b_q <= word_i[ATT_B_LSB +: ATT_W];
    end
  end

  tcd_pulse #(.RST_LEN(RST_LEN)) i_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_i && dec.rst_req),
    .busy_o  (mod_rst_o)
  );

  assign brd_sel_o   = dec_q.sel;
  assign pair_test_o = dec_q.pair;
  assign test_y_o    = dec_q.y;
  assign rf_en_o     = dec_q.en;
  assign att_a_o     = att_a_q;
  assign att_b_o     = att_b_q;
endmodule

// File: rtl/tcd_checker.sv
module tcd_checker
  import tcd_pkg::*;
#(
  parameter int unsigned RST_LEN = 16,
  localparam int unsigned RUN_W  = $clog2(RST_LEN + 2)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic [WORD_W-1:0]  word_i,
  input logic [NUM_BRD-1:0] brd_sel_o,
  input logic               pair_test_o,
  input logic               test_y_o,
  input logic               rf_en_o,
  input logic [ATT_W-1:0]   att_a_o,
  input logic [ATT_W-1:0]   att_b_o,
  input logic               mod_rst_o
);
  logic rst_wr;
  logic [RUN_W-1:0] run_q;
  assign rst_wr = wr_i && ((word_i[CMD_W-1:0] == '0) || (word_i[CMD_W-1:0] == '1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              run_q <= '0;
    else if (rst_wr)                          run_q <= RUN_W'(1);
    else if (mod_rst_o && run_q <= RUN_W'(RST_LEN)) run_q <= run_q + 1'b1;
    else if (!mod_rst_o)                      run_q <= '0;
  end

  a_r1_att_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (att_a_o == $past(word_i[ATT_A_LSB +: ATT_W])) &&
             (att_b_o == $past(word_i[ATT_B_LSB +: ATT_W])));
  a_r3_at_most_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(brd_sel_o) <= 2);
  a_r3_axis_only_in_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_y_o |-> pair_test_o);
  a_r4_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_wr |=> mod_rst_o && (brd_sel_o == '0) && !rf_en_o);
  a_r5_pulse_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_rst_o |-> run_q <= RUN_W'(RST_LEN));
  a_r5_pulse_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_rst_o && run_q == RUN_W'(RST_LEN) && !rst_wr) |=> !mod_rst_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(brd_sel_o) && $stable(att_a_o) && $stable(att_b_o) &&
              $stable(test_y_o) && $stable(pair_test_o));
  a_r9_en_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_en_o == (brd_sel_o != '0));
endmodule

bind tst_cmd_decoder tcd_checker #(.RST_LEN(RST_LEN)) i_tcd_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .word_i      (word_i),
  .brd_sel_o   (brd_sel_o),
  .pair_test_o (pair_test_o),
  .test_y_o    (test_y_o),
  .rf_en_o     (rf_en_o),
  .att_a_o     (att_a_o),
  .att_b_o     (att_b_o),
  .mod_rst_o   (mod_rst_o)
);

// File: tb/test_tst_cmd_decoder.sv
`timescale 1ns/1ps
module test_tst_cmd_decoder;
  localparam int RST_LEN = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] word_i = '0;
  logic [5:0]  brd_sel_o;
  logic        pair_test_o, test_y_o, rf_en_o, mod_rst_o;
  logic [3:0]  att_a_o, att_b_o;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct packed {
    logic [5:0] sel;
    logic pair, y, en, rst;
    logic [3:0] a, b;
  } exp_t;
  exp_t q[$];

  always #5 clk_i = ~clk_i;

  tst_cmd_decoder #(.RST_LEN(RST_LEN)) i_tst_cmd_decoder (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // model from the requirements
  function automatic exp_t model(input logic [15:0] w);
    exp_t e = '0;
    logic [3:0] c = w[3:0];
    e.a = w[7:4];
    e.b = w[11:8];
    if (c >= 1 && c <= 6) begin
      e.sel = 6'(1 << (c - 1)); e.en = 1'b1;
    end else if (c >= 8 && c <= 11) begin
      e.sel = c[1] ? 6'b001100 : 6'b000011;
      e.pair = 1'b1; e.y = c[0]; e.en = 1'b1;
    end
    e.rst = (c == 4'h0) || (c == 4'hf);
    return e;
  endfunction

  task automatic write(input logic [15:0] w);
    @(negedge clk_i);
    q.push_back(model(w));
    wr_i = 1'b1; word_i = w;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  // monitor
  always @(posedge clk_i) begin
    if (wr_i && rst_ni) begin
      exp_t e;
      #2;
      e = q.pop_front();
      check("R1 att_a", att_a_o, e.a);
      check("R1 att_b", att_b_o, e.b);
      check("R2/R3/R4/R6 sel", brd_sel_o, e.sel);
      check("R3 pair", pair_test_o, e.pair);
      check("R3 axis", test_y_o, e.y);
      check("R9 rf_en", rf_en_o, e.en);
      if (e.rst) check("R4 pulse start", mod_rst_o, 1);
    end
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic [5:0] s0;
    #1;
    // R8 reset state
    check("R8 sel", brd_sel_o, 0);
    check("R8 en", rf_en_o, 0);
    check("R8 rst", mod_rst_o, 0);
    check("R8 att", {att_a_o, att_b_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 R3 R6: every non-reset code, varied attenuators and spare bits (R7)
    for (int c = 1; c < 15; c++) begin
      write({4'(c * 3), 4'(15 - c), 4'(c), 4'(c)});
      @(negedge clk_i);
      check("R6 no pulse", mod_rst_o, 0);
    end
    write(16'h5A33);
    write(16'hF0CA);

    // R7 hold: bus changes without strobe
    s0 = brd_sel_o;
    @(negedge clk_i); word_i = 16'h0F01;
    repeat (4) @(negedge clk_i);
    check("R7 hold sel", brd_sel_o, s0);
    check("R7 hold att_a", att_a_o, 4'hC);
    check("R7 hold att_b", att_b_o, 4'h0);

    // R4 R5 reset code 0000, length
    write(16'h0290);
    n = 0;
    while (mod_rst_o && n < 100) begin n++; @(negedge clk_i); end
    check("R5 pulse len", n, RST_LEN);

    // R4 code 1111, restart mid pulse
    write(16'h0006);
    write(16'h031F);
    repeat (5) @(negedge clk_i);
    write(16'h0F4F);
    n = 0;
    while (mod_rst_o && n < 100) begin n++; @(negedge clk_i); end
    check("R5 restart len", n, RST_LEN);
    check("R4 sel after reset", brd_sel_o, 0);

    // R7 spare bits only differ
    write(16'hF00B);
    write(16'h000B);
    check("R7 spare", {pair_test_o, test_y_o, brd_sel_o}, {2'b11, 6'b001100});

    repeat (3) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule